// File: doc/BRIEF.md
# Instruction Pointer and Branch Unit

This unit owns the word-addressed instruction pointer of a small 16-bit processor. Each cycle in which the advance strobe is high, it looks at the opcode of the instruction now executing and chooses the next fetch address. That address is one of four values: the pointer plus one, the pointer plus two, a 16-bit immediate taken from the second instruction word, or a register operand. It also reports on the next cycle whether the last update was a jump, so that the surrounding pipeline can discard fetched words.

The instruction length follows from the opcode alone. Opcodes from the extended threshold (0x20) upward span two words, and the opcodes below it span one. Six conditional jumps form a contiguous family. Each one tests the zero, lesser or greater flag, with either polarity. The unit also presents the pointer plus one at all times, which is the value that the load-pointer instruction writes into a register.

Top module: `ip_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer becomes 0x0000 and `taken_o` becomes 0 after that edge.
- R2: At an edge where `adv` is low, the pointer keeps its value and `taken_o` is 0 after the edge, whatever the opcode and flags are.
- R3: With `adv` high, a non-jump opcode below 0x20 (any value other than 0x18) moves the pointer to pointer+1.
- R4: With `adv` high, a non-jump opcode of 0x20 or above (0x20, or 0x28 to 0xFF) moves the pointer to pointer+2.
- R5: With `adv` high, opcode 0x21 loads the pointer from `imm_i`, whatever the flags are.
- R6: With `adv` high, opcode 0x18 loads the pointer from `reg_i`.
- R7: With `adv` high, opcode 0x22 loads `imm_i` when `zero_i` is 1, and opcode 0x23 loads `imm_i` when `zero_i` is 0.
- R8: With `adv` high, opcode 0x24 jumps when `less_i` is 1, and opcode 0x25 jumps when `less_i` is 0.
- R9: With `adv` high, opcode 0x26 jumps when `greater_i` is 1, and opcode 0x27 jumps when `greater_i` is 0.
- R10: A conditional jump (0x22 to 0x27) whose condition fails moves the pointer to pointer+2.
- R11: `taken_o` is 1 for exactly the cycle that follows an advancing edge on which the pointer was loaded from `imm_i` or `reg_i`, and 0 otherwise.
- R12: `ret_o` always equals the current pointer plus one, modulo 2^16.
- R13: Increments wrap modulo 2^16: from 0xFFFF, a one-word step gives 0x0000 and a two-word step gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe; the pointer updates only when this is high |
| opcode_i | input | 8 | Opcode of the executing instruction |
| imm_i | input | 16 | Immediate from the second instruction word |
| reg_i | input | 16 | Register operand for the register-indirect jump |
| zero_i | input | 1 | Zero flag |
| less_i | input | 1 | Lesser flag |
| greater_i | input | 1 | Greater flag |
| ip_o | output | 16 | Current instruction pointer |
| taken_o | output | 1 | Previous update was a jump load |
| ret_o | output | 16 | Pointer plus one, for the load-pointer instruction |

## Verification
The hardest situations to reach are the address wrap and a conditional jump whose condition fails. The wrap only shows up at 0xFFFF, and the failed condition returns pointer+2, which differs from both the sequential one-word step and the jump target. The bench reaches 0xFFFF directly: it issues an unconditional jump with that immediate, then follows it with a one-word opcode and with a two-word opcode. It then sweeps all six conditional opcodes against both states of the flag each one tests. On top of this it runs random opcodes that are biased toward the 0x18 to 0x27 band, with random flags and random stalls on the advance strobe.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    localparam logic [7:0] OP_JMPR = 8'h18;
    localparam logic [7:0] OP_LDIP = 8'h19;
    localparam logic [7:0] OP_JMP  = 8'h21;
    localparam logic [7:0] OP_JZ   = 8'h22;
    localparam logic [7:0] OP_JNZ  = 8'h23;
    localparam logic [7:0] OP_JNG  = 8'h27;

    typedef enum logic [1:0] {
        JK_NONE,
        JK_IMM,
        JK_REG,
        JK_COND
    } jump_kind_e;

    typedef enum logic [1:0] {
        FS_NONE,
        FS_ZERO,
        FS_LESS,
        FS_GREATER
    } flag_sel_e;

    typedef struct packed {
        jump_kind_e kind;
        flag_sel_e  flag;
        logic       on_clear;
        logic       two_word;
    } op_info_t;

    typedef struct packed {
        logic zero;
        logic less;
        logic greater;
    } flags_t;

    function automatic logic pick_flag(input flags_t f, input flag_sel_e s);
        logic v;
        case (s)
            FS_ZERO:    v = f.zero;
            FS_LESS:    v = f.less;
            FS_GREATER: v = f.greater;
            default:    v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ipu_op_decode.sv
module ipu_op_decode
    import ipu_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter logic [OPC_W-1:0] EXT_BASE = 'h20
) (
    input  logic [OPC_W-1:0] opcode,
    output op_info_t         info
);
    localparam logic [OPC_W-1:0] JMPR_C = OPC_W'(OP_JMPR);
    localparam logic [OPC_W-1:0] JMP_C  = OPC_W'(OP_JMP);
    localparam logic [OPC_W-1:0] COND_LO = OPC_W'(OP_JZ);
    localparam logic [OPC_W-1:0] COND_HI = OPC_W'(OP_JNG);

    logic in_cond_band;

    assign in_cond_band = (opcode >= COND_LO) && (opcode <= COND_HI);

    always_comb begin
        info.two_word = (opcode >= EXT_BASE);
        info.kind     = JK_NONE;
        info.flag     = FS_NONE;
        info.on_clear = 1'b0;
        if (opcode == JMP_C) begin
            info.kind = JK_IMM;
        end else if (opcode == JMPR_C) begin
            info.kind = JK_REG;
        end else if (in_cond_band) begin
            // bits [2:1] pick the flag, bit 0 inverts the test
            info.kind     = JK_COND;
            info.on_clear = opcode[0];
            case (opcode[2:1])
                2'b01:   info.flag = FS_ZERO;
                2'b10:   info.flag = FS_LESS;
                default: info.flag = FS_GREATER;
            endcase
        end
    end

endmodule

// File: rtl/ipu_cond_eval.sv
module ipu_cond_eval
    import ipu_pkg::*;
(
    input  op_info_t info,
    input  flags_t   flags,
    output logic     take
);
    logic cond_ok;

    assign cond_ok = pick_flag(flags, info.flag) ^ info.on_clear;

    always_comb begin
        case (info.kind)
            JK_IMM, JK_REG: take = 1'b1;
            JK_COND:        take = cond_ok;
            default:        take = 1'b0;
        endcase
    end

endmodule

// File: rtl/ipu_next_addr.sv
module ipu_next_addr
    import ipu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ip,
    input  logic [ADDR_W-1:0] imm,
    input  logic [ADDR_W-1:0] reg_val,
    input  op_info_t          info,
    input  logic              take,
    output logic [ADDR_W-1:0] next_ip
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] seq_ip;
    logic [ADDR_W-1:0] target;

    assign step   = info.two_word ? ADDR_W'(2) : ADDR_W'(1);
    assign seq_ip = ip + step;
    assign target = (info.kind == JK_REG) ? reg_val : imm;
    assign next_ip = take ? target : seq_ip;

endmodule

// File: rtl/ip_branch_unit.sv
module ip_branch_unit
    import ipu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OPC_W  = 8,
    parameter logic [OPC_W-1:0]  EXT_BASE = 'h20,
    parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [ADDR_W-1:0] imm_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic              zero_i,
    input  logic              less_i,
    input  logic              greater_i,
    output logic [ADDR_W-1:0] ip_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] ret_o
);
    op_info_t          info;
    flags_t            flags;
    logic              take;
    logic [ADDR_W-1:0] next_ip;
    logic [ADDR_W-1:0] ip_q;
    logic              taken_q;

    assign flags = '{zero: zero_i, less: less_i, greater: greater_i};

    ipu_op_decode #(.OPC_W(OPC_W), .EXT_BASE(EXT_BASE)) u_dec (
        .opcode (opcode_i),
        .info   (info)
    );

    ipu_cond_eval u_cond (
        .info  (info),
        .flags (flags),
        .take  (take)
    );

    ipu_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
        .ip      (ip_q),
        .imm     (imm_i),
        .reg_val (reg_i),
        .info    (info),
        .take    (take),
        .next_ip (next_ip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q    <= RESET_IP;
            taken_q <= 1'b0;
        end else if (adv_i) begin
            ip_q    <= next_ip;
            taken_q <= take;
        end else begin
            taken_q <= 1'b0;
        end
    end

    assign ip_o    = ip_q;
    assign taken_o = taken_q;
    assign ret_o   = ip_q + ADDR_W'(1);

endmodule

// File: rtl/ip_branch_unit_chk.sv
module ip_branch_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int OPC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_i,
    input logic [OPC_W-1:0]  opcode_i,
    input logic [ADDR_W-1:0] imm_i,
    input logic [ADDR_W-1:0] reg_i,
    input logic              zero_i,
    input logic [ADDR_W-1:0] ip_o,
    input logic              taken_o
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ip_o == '0) && !taken_o);

    a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(ip_o) && !taken_o);

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && opcode_i < OPC_W'(8'h20) && opcode_i != OPC_W'(8'h18))
        |=> (ip_o == $past(ip_o) + ADDR_W'(1)) && !taken_o);

    a_r4_double_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && (opcode_i == OPC_W'(8'h20) || opcode_i >= OPC_W'(8'h28)))
        |=> (ip_o == $past(ip_o) + ADDR_W'(2)) && !taken_o);

    a_r5_jmp_imm: assert property (@(posedge clk) disable iff (rst)
        (adv_i && opcode_i == OPC_W'(8'h21)) |=> (ip_o == $past(imm_i)) && taken_o);

    a_r6_jmp_reg: assert property (@(posedge clk) disable iff (rst)
        (adv_i && opcode_i == OPC_W'(8'h18)) |=> (ip_o == $past(reg_i)) && taken_o);

    a_r7_jz_taken: assert property (@(posedge clk) disable iff (rst)
        (adv_i && opcode_i == OPC_W'(8'h22) && zero_i) |=> (ip_o == $past(imm_i)));

    a_r10_jnz_fall: assert property (@(posedge clk) disable iff (rst)
        (adv_i && opcode_i == OPC_W'(8'h23) && zero_i)
        |=> (ip_o == $past(ip_o) + ADDR_W'(2)) && !taken_o);

    a_r11_taken_needs_adv: assert property (@(posedge clk) disable iff (rst)
        $rose(taken_o) |-> $past(adv_i));

endmodule

bind ip_branch_unit ip_branch_unit_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv_i),
    .opcode_i (opcode_i),
    .imm_i    (imm_i),
    .reg_i    (reg_i),
    .zero_i   (zero_i),
    .ip_o     (ip_o),
    .taken_o  (taken_o)
);

// File: tb/ip_branch_unit_bench.sv
`timescale 1ns/1ps
module ip_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [15:0] imm_i = '0;
    logic [15:0] reg_i = '0;
    logic        zero_i = 1'b0;
    logic        less_i = 1'b0;
    logic        greater_i = 1'b0;
    logic [15:0] ip_o;
    logic        taken_o;
    logic [15:0] ret_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_ip = '0;
    logic        exp_taken = 1'b0;

    always #2.5 clk = ~clk;

    ip_branch_unit u_ip_branch_unit (
        .clk(clk), .rst(rst), .adv_i(adv_i), .opcode_i(opcode_i),
        .imm_i(imm_i), .reg_i(reg_i), .zero_i(zero_i), .less_i(less_i),
        .greater_i(greater_i), .ip_o(ip_o), .taken_o(taken_o), .ret_o(ret_o)
    );

    // expected jump decision from the requirement list
    function automatic logic model_take(input logic [7:0] op, input logic z,
                                        input logic l, input logic g);
        case (op)
            8'h21, 8'h18: return 1'b1;
            8'h22: return z;
            8'h23: return !z;
            8'h24: return l;
            8'h25: return !l;
            8'h26: return g;
            8'h27: return !g;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] model_next(input logic [7:0] op, input logic [15:0] ip,
                                               input logic [15:0] imm, input logic [15:0] rv,
                                               input logic z, input logic l, input logic g);
        if (model_take(op, z, l, g)) return (op == 8'h18) ? rv : imm;
        return ip + ((op >= 8'h20) ? 16'd2 : 16'd1);
    endfunction

    function automatic string tag_of(input logic [7:0] op, input logic a, input logic tk);
        if (!a) return "R2";
        if (op == 8'h21) return "R5";
        if (op == 8'h18) return "R6";
        if (op >= 8'h22 && op <= 8'h27 && !tk) return "R10";
        if (op == 8'h22 || op == 8'h23) return "R7";
        if (op == 8'h24 || op == 8'h25) return "R8";
        if (op == 8'h26 || op == 8'h27) return "R9";
        if (op < 8'h20) return "R3";
        return "R4";
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, check at the following negedge
    task automatic step(input logic a, input logic [7:0] op, input logic [15:0] imm,
                        input logic [15:0] rv, input logic z, input logic l, input logic g,
                        input string forced_tag);
        logic tk;
        string tg;
        adv_i = a; opcode_i = op; imm_i = imm; reg_i = rv;
        zero_i = z; less_i = l; greater_i = g;
        tk = model_take(op, z, l, g);
        tg = (forced_tag != "") ? forced_tag : tag_of(op, a, tk);
        if (a) exp_ip = model_next(op, exp_ip, imm, rv, z, l, g);
        exp_taken = a && tk;
        @(posedge clk);
        @(negedge clk);
        check16(tg, ip_o, exp_ip);
        check16({tg, "/R11"}, {15'd0, taken_o}, {15'd0, exp_taken});
        check16("R12", ret_o, exp_ip + 16'd1);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        @(negedge clk);
        check16("R1", ip_o, 16'h0000);
        check16("R1", {15'd0, taken_o}, 16'd0);
        rst = 1'b0;
        exp_ip = '0;

        step(1'b1, 8'h00, 16'h1234, 16'h0, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 8'h20, 16'h1234, 16'h0, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 8'h19, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 8'h21, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 8'h21, 16'h9999, 16'h0, 1'b1, 1'b1, 1'b1, "R2");
        step(1'b1, 8'h18, 16'h0, 16'hBEEF, 1'b0, 1'b0, 1'b0, "R6");
        step(1'b1, 8'h28, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 8'hFF, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R4");

        // wrap at the top of the address space
        step(1'b1, 8'h21, 16'hFFFF, 16'h0, 1'b0, 1'b0, 1'b0, "R13");
        step(1'b1, 8'h05, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R13");
        step(1'b1, 8'h21, 16'hFFFF, 16'h0, 1'b0, 1'b0, 1'b0, "R13");
        step(1'b1, 8'h20, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R13");

        // every conditional against both states of its flag
        for (int op = 8'h22; op <= 8'h27; op++) begin
            for (int f = 0; f < 2; f++) begin
                step(1'b1, 8'(op), 16'h0100 + 16'(op * 4 + f), 16'h0,
                     f[0], f[0], f[0], "");
                step(1'b1, 8'(op), 16'h0200 + 16'(op), 16'h0,
                     !f[0], f[0], !f[0], "");
            end
        end

        for (int i = 0; i < 600; i++) begin
            logic [7:0] op;
            case ($urandom % 4)
                0: op = 8'h20 + 8'($urandom % 8);
                1: op = 8'h18 + 8'($urandom % 2);
                2: op = 8'($urandom % 256);
                default: op = 8'($urandom % 48);
            endcase
            step(($urandom % 5) != 0, op, 16'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule